// File: doc/BRIEF.md
# CPU and Peripheral Clock-Enable Prescaler with Double-Speed Mode

This block runs on the oscillator clock and turns it into single-cycle clock-enable pulses. One pulse train goes to the core's phase generator. Five further trains go to timer 0, timer 1, the UART, the watchdog and the smart card interface. No derived clock is gated. Instead, every consumer stays on the oscillator clock and advances only in cycles where its enable is high.

A 3-bit reload value sets a first prescaler. The all-ones value passes every oscillator cycle through. Any other value r produces one tick every 2*(7-r) cycles. After the prescaler comes a fixed divide-by-two stage. That stage is used in standard mode and bypassed in double-speed mode.

Each peripheral has a fast bit. A fast bit lets its peripheral follow the bypassed rate, but only while double-speed mode is in force. Otherwise every peripheral follows the divided rate. A new reload value waits for the prescaler count to expire. A new mode waits for a divide-by-two boundary. The pulse spacing therefore never takes a value that belongs to neither the old nor the new setting.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: With double-speed mode active, `core_ce` pulses once every P oscillator cycles, where P is 1 for reload value 7 and 2*(7-r) for reload value r in 0..6.
- R2: In standard mode, `core_ce` pulses once every 2*P oscillator cycles and never in two consecutive cycles.
- R3: While `rst_n` is low, all enables and `x2_active` are low. After reset the block uses reload 7, standard mode and all fast bits clear, so `core_ce` and every `periph_ce` bit pulse every 2 cycles.
- R4: A write with `wr_en` high and `wr_addr` 0 loads `wr_data[2:0]` as the reload value. With `wr_addr` 1 it loads `wr_data[0]` as the double-speed bit and `wr_data[5:1]` as the fast bits for `periph_ce[4:0]` (0 timer 0, 1 timer 1, 2 UART, 3 watchdog, 4 smart card).
- R5: With double-speed mode active, a peripheral whose fast bit is set pulses every P cycles, and one whose fast bit is clear pulses every 2*P cycles.
- R6: With double-speed mode inactive, the fast bits have no effect, and every `periph_ce` bit pulses in exactly the cycles of `core_ce`.
- R7: A new reload value is applied only when the running prescaler count expires. The interval in progress completes at its old length, and the next interval uses the new one.
- R8: A change of the double-speed bit reaches `x2_active` only in the cycle after a divide-by-two boundary (a cycle in which `core_ce` pulsed). During the switch, every interval between `core_ce` pulses equals either the old or the new period, and the old period never reappears once the new one has begun.
- R9: A `periph_ce` bit is high only in cycles in which `core_ce` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the reload register, 1 the speed register |
| wr_data | input | 6 | Write data |
| core_ce | output | 1 | Clock enable for the core phase generator |
| periph_ce | output | 5 | Clock enables for timer 0, timer 1, UART, watchdog, smart card |
| x2_active | output | 1 | Double-speed mode currently in force |

## Verification
The rate tests cover every reload value, in both modes and with several fast-bit masks. Each test counts pulses and measures every gap over a window that all periods divide exactly. Count and gap checks together separate a wrong divisor, a wrong mode and uneven spacing.

Pairs of settings that differ only in whether the double-speed bit is set show that the fast bits are gated. Two masks of alternating fast bits expose a swapped or shared peripheral index.

Timed tests cover the switching rules:
- A reload write in the middle of a long count must leave that interval at 14 cycles and make the next one a single cycle.
- Mode flips in each direction must show only old or new gaps, in order, with the mode change landing right after a pulse.

Resets at start-up and in the middle of a run must both restore the default rate.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
  localparam int RELOAD_W   = 3;
  localparam int NUM_PERIPH = 5;

  typedef enum logic [0:0] {
    REG_RELOAD = 1'b0,
    REG_SPEED  = 1'b1
  } clkpre_reg_e;
endpackage

// File: rtl/clkpre_rst_sync.sv
module clkpre_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/clkpre_tick_gen.sv
module clkpre_tick_gen #(
  parameter int RW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reload,
  output logic          pre_tick,
  output logic [CW-1:0] cnt
);
  localparam int MAXR = (2 ** RW) - 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign pre_tick = (cnt_q == '0);
  assign cnt      = cnt_q;

  // the reload value is consulted only at terminal count
  always_comb begin
    if (!pre_tick)                cnt_d = cnt_q - 1'b1;
    else if (reload == RW'(MAXR)) cnt_d = '0;
    else                          cnt_d = CW'(2 * (MAXR - int'(reload)) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkpre_half_stage.sv
module clkpre_half_stage #(
  parameter int NP = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tick,
  input  logic          x2_req,
  input  logic [NP-1:0] fast_req,
  output logic          half_tick,
  output logic          x2_eff,
  output logic [NP-1:0] fast_eff
);
  logic          half_q, half_d;
  logic          x2_q, x2_d;
  logic [NP-1:0] fast_q, fast_d;

  assign half_tick = pre_tick & half_q;
  assign x2_eff    = x2_q;
  assign fast_eff  = fast_q;

  // mode bits move only on a divide-by-two boundary
  always_comb begin
    half_d = pre_tick ? ~half_q : half_q;
    x2_d   = half_tick ? x2_req : x2_q;
    fast_d = half_tick ? fast_req : fast_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      x2_q   <= 1'b0;
      fast_q <= '0;
    end else begin
      half_q <= half_d;
      x2_q   <= x2_d;
      fast_q <= fast_d;
    end
  end
endmodule

// File: rtl/clkpre_ce_mux.sv
module clkpre_ce_mux #(
  parameter int NP = 5
) (
  input  logic          pre_tick,
  input  logic          half_tick,
  input  logic          x2_eff,
  input  logic [NP-1:0] fast_eff,
  output logic          core_ce,
  output logic [NP-1:0] periph_ce
);
  assign core_ce = x2_eff ? pre_tick : half_tick;

  for (genvar g = 0; g < NP; g++) begin : g_periph
    assign periph_ce[g] = (x2_eff & fast_eff[g]) ? pre_tick : half_tick;
  end
endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler #(
  parameter int RELOAD_W   = clkpre_pkg::RELOAD_W,
  parameter int NUM_PERIPH = clkpre_pkg::NUM_PERIPH,
  localparam int CNT_W  = $clog2(2 * ((2 ** RELOAD_W) - 1)),
  localparam int DATA_W = (NUM_PERIPH + 1 > RELOAD_W) ? NUM_PERIPH + 1 : RELOAD_W
) (
  input  logic                  clk_osc,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  core_ce,
  output logic [NUM_PERIPH-1:0] periph_ce,
  output logic                  x2_active
);
  import clkpre_pkg::*;

  logic                  rst_int_n;
  logic [RELOAD_W-1:0]   reload_q, reload_d;
  logic                  x2_q, x2_d;
  logic [NUM_PERIPH-1:0] fast_q, fast_d;
  logic                  pre_tick, half_tick;
  logic [CNT_W-1:0]      tick_cnt;
  logic [NUM_PERIPH-1:0] fast_eff;

  clkpre_rst_sync u_rst (
    .clk       (clk_osc),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  always_comb begin
    reload_d = reload_q;
    x2_d     = x2_q;
    fast_d   = fast_q;
    if (wr_en) begin
      if (wr_addr == 1'(REG_RELOAD)) begin
        reload_d = wr_data[RELOAD_W-1:0];
      end else begin
        x2_d   = wr_data[0];
        fast_d = wr_data[NUM_PERIPH:1];
      end
    end
  end

  always_ff @(posedge clk_osc or negedge rst_int_n) begin
    if (!rst_int_n) begin
      reload_q <= '1;
      x2_q     <= 1'b0;
      fast_q   <= '0;
    end else begin
      reload_q <= reload_d;
      x2_q     <= x2_d;
      fast_q   <= fast_d;
    end
  end

  clkpre_tick_gen #(.RW(RELOAD_W), .CW(CNT_W)) u_tick (
    .clk      (clk_osc),
    .rst_n    (rst_int_n),
    .reload   (reload_q),
    .pre_tick (pre_tick),
    .cnt      (tick_cnt)
  );

  clkpre_half_stage #(.NP(NUM_PERIPH)) u_half (
    .clk       (clk_osc),
    .rst_n     (rst_int_n),
    .pre_tick  (pre_tick),
    .x2_req    (x2_q),
    .fast_req  (fast_q),
    .half_tick (half_tick),
    .x2_eff    (x2_active),
    .fast_eff  (fast_eff)
  );

  clkpre_ce_mux #(.NP(NUM_PERIPH)) u_mux (
    .pre_tick  (pre_tick),
    .half_tick (half_tick),
    .x2_eff    (x2_active),
    .fast_eff  (fast_eff),
    .core_ce   (core_ce),
    .periph_ce (periph_ce)
  );
endmodule

// File: rtl/clkpre_checker.sv
module clkpre_checker #(
  parameter int NP = 5,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_ce,
  input logic [NP-1:0] periph_ce,
  input logic          x2_active,
  input logic          half_tick,
  input logic [CW-1:0] cnt
);
  AST_PERIPH_INSIDE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ce & ~{NP{core_ce}}) == '0); // R9

  AST_STD_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ce && $past(core_ce)) |-> x2_active); // R2

  AST_MODE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(x2_active) |-> $past(half_tick)); // R8

  AST_COUNT_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0) |-> (cnt == $past(cnt) - CW'(1))); // R7

  AST_STD_PERIPH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !x2_active |-> (periph_ce == {NP{core_ce}})); // R6
endmodule

bind cpu_clk_prescaler clkpre_checker #(.NP(NUM_PERIPH), .CW(CNT_W)) u_chk (
  .clk       (clk_osc),
  .rst_n     (rst_n),
  .core_ce   (core_ce),
  .periph_ce (periph_ce),
  .x2_active (x2_active),
  .half_tick (half_tick),
  .cnt       (tick_cnt)
);

// File: tb/test_cpu_clk_prescaler.sv
module test_cpu_clk_prescaler;
  localparam int NP  = clkpre_pkg::NUM_PERIPH;
  localparam int WIN = 1680;
  localparam int NV  = 12;

  // {reload[2:0], x2, fast[4:0], core[4:0], p4, p3, p2, p1, p0}
  localparam logic [38:0] VEC [NV] = '{
    {3'd7, 1'b0, 5'b00000, 5'd2,  5'd2,  5'd2,  5'd2,  5'd2,  5'd2 },
    {3'd7, 1'b1, 5'b00000, 5'd1,  5'd2,  5'd2,  5'd2,  5'd2,  5'd2 },
    {3'd7, 1'b1, 5'b10101, 5'd1,  5'd1,  5'd2,  5'd1,  5'd2,  5'd1 },
    {3'd6, 1'b0, 5'b11111, 5'd4,  5'd4,  5'd4,  5'd4,  5'd4,  5'd4 },
    {3'd3, 1'b1, 5'b01010, 5'd8,  5'd16, 5'd8,  5'd16, 5'd8,  5'd16},
    {3'd0, 1'b0, 5'b00000, 5'd28, 5'd28, 5'd28, 5'd28, 5'd28, 5'd28},
    {3'd0, 1'b1, 5'b11111, 5'd14, 5'd14, 5'd14, 5'd14, 5'd14, 5'd14},
    {3'd5, 1'b1, 5'b00001, 5'd4,  5'd8,  5'd8,  5'd8,  5'd8,  5'd4 },
    {3'd4, 1'b0, 5'b00000, 5'd12, 5'd12, 5'd12, 5'd12, 5'd12, 5'd12},
    {3'd1, 1'b1, 5'b00000, 5'd12, 5'd24, 5'd24, 5'd24, 5'd24, 5'd24},
    {3'd2, 1'b0, 5'b01100, 5'd20, 5'd20, 5'd20, 5'd20, 5'd20, 5'd20},
    {3'd2, 1'b1, 5'b11000, 5'd10, 5'd10, 5'd10, 5'd20, 5'd20, 5'd20}
  };

  logic          clk_osc;
  logic          rst_n;
  logic          wr_en;
  logic          wr_addr;
  logic [5:0]    wr_data;
  logic          core_ce;
  logic [NP-1:0] periph_ce;
  logic          x2_active;

  int compared   = 0;
  int mismatched = 0;

  cpu_clk_prescaler i_cpu_clk_prescaler (
    .clk_osc   (clk_osc),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .core_ce   (core_ce),
    .periph_ce (periph_ce),
    .x2_active (x2_active)
  );

  initial clk_osc = 1'b0;
  always #5 clk_osc = ~clk_osc;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [5:0] d);
    @(negedge clk_osc);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_osc);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int exp_core, input int exp_p [NP], input string tag);
    int n_core = 0, bad_core = 0, last_core = -1, stray = 0;
    int n_p [NP];
    int bad_p [NP];
    int last_p [NP];
    for (int i = 0; i < NP; i++) begin n_p[i] = 0; bad_p[i] = 0; last_p[i] = -1; end
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk_osc);
      if (core_ce) begin
        if (last_core >= 0 && k - last_core != exp_core) bad_core++;
        last_core = k; n_core++;
      end
      for (int i = 0; i < NP; i++) begin
        if (periph_ce[i]) begin
          if (last_p[i] >= 0 && k - last_p[i] != exp_p[i]) bad_p[i]++;
          last_p[i] = k; n_p[i]++;
        end
      end
      if ((periph_ce & ~{NP{core_ce}}) != '0) stray++;
    end
    check(n_core == WIN / exp_core && bad_core == 0, {tag, " R1 R2 core rate"},
          n_core, WIN / exp_core);
    for (int i = 0; i < NP; i++)
      check(n_p[i] == WIN / exp_p[i] && bad_p[i] == 0, {tag, " R5 R6 periph rate"},
            n_p[i], WIN / exp_p[i]);
    check(stray == 0, {tag, " R9 periph outside core"}, stray, 0);
  endtask

  task automatic switch_test(input bit to_x2, input string tag);
    int last = -1, prev_gap = 0, bad_gap = 0, changes = 0, bad_align = 0;
    logic prev_x2 = ~to_x2;
    logic prev_core = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_osc);
      wr_en = (k == 4); wr_addr = 1'b1; wr_data = {5'b00000, to_x2};
      if (x2_active != prev_x2) begin
        changes++;
        if (!prev_core) bad_align++;
      end
      if (core_ce) begin
        if (last >= 0) begin
          if (k - last != 2 && k - last != 4) bad_gap++;
          if (to_x2 && prev_gap == 2 && k - last == 4) bad_gap++;
          if (!to_x2 && prev_gap == 4 && k - last == 2) bad_gap++;
          prev_gap = k - last;
        end
        last = k;
      end
      prev_x2 = x2_active; prev_core = core_ce;
    end
    wr_en = 1'b0;
    check(bad_gap == 0, {tag, " R8 switch gaps"}, bad_gap, 0);
    check(changes == 1 && bad_align == 0, {tag, " R8 switch alignment"}, changes, 1);
    check(x2_active == to_x2, {tag, " R8 final mode"}, int'(x2_active), int'(to_x2));
  endtask

  initial begin
    repeat (100000) @(posedge clk_osc);
    mismatched++; compared++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int two [NP];
    int ep [NP];
    int quiet;
    int gap;
    for (int i = 0; i < NP; i++) two[i] = 2;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;

    // R3: quiet while in reset
    quiet = 0;
    repeat (3) begin
      @(negedge clk_osc);
      if (core_ce || periph_ce != '0 || x2_active) quiet++;
    end
    check(quiet == 0, "R3 outputs low in reset", quiet, 0);
    @(negedge clk_osc); rst_n = 1'b1;
    repeat (4) @(negedge clk_osc);
    check(x2_active == 1'b0, "R3 mode after reset", int'(x2_active), 0);
    measure(2, two, "R3 default");

    // R4: vector table through both registers
    for (int v = 0; v < NV; v++) begin
      write_reg(1'b0, {3'b000, VEC[v][38:36]});
      write_reg(1'b1, {VEC[v][34:30], VEC[v][35]});
      repeat (120) @(negedge clk_osc);
      check(x2_active == VEC[v][35], "R4 mode bit", int'(x2_active), int'(VEC[v][35]));
      for (int i = 0; i < NP; i++) ep[i] = int'(VEC[v][5*i+4 -: 5]);
      measure(int'(VEC[v][29:25]), ep, $sformatf("vec%0d", v));
    end

    // R7: reload change mid-count waits for terminal count
    write_reg(1'b1, 6'b000001);
    write_reg(1'b0, 6'd0);
    repeat (120) @(negedge clk_osc);
    do @(negedge clk_osc); while (!core_ce);
    gap = 0;
    do begin
      @(negedge clk_osc);
      gap++;
      wr_en = (gap == 3); wr_addr = 1'b0; wr_data = 6'd7;
    end while (!core_ce && gap < 40);
    wr_en = 1'b0;
    check(gap == 14, "R7 old interval completes", gap, 14);
    @(negedge clk_osc);
    check(core_ce == 1'b1, "R7 new interval applied", int'(core_ce), 1);

    // R8: mode switches in both directions at reload 6
    write_reg(1'b1, 6'b000000);
    write_reg(1'b0, 6'd6);
    repeat (60) @(negedge clk_osc);
    switch_test(1'b1, "to x2");
    switch_test(1'b0, "to std");

    // R3: reset in the middle of a run restores defaults
    write_reg(1'b0, 6'd0);
    write_reg(1'b1, 6'b111111);
    repeat (60) @(negedge clk_osc);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_osc);
    check(core_ce == 1'b0 && x2_active == 1'b0, "R3 mid-run reset quiet",
          int'(core_ce), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_osc);
    measure(2, two, "R3 after second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule